// File: doc/BRIEF.md
# Time-Interleaved Parallel Bus Capture

This block records an 8-bit parallel bus at a combined rate higher than one capture lane could sustain. Several identical lanes share a single free-running time counter. A capture is armed with a future counter value and a byte count. Each lane then takes every LANES-th sample of the stream, at instants staggered by a fixed step according to its index. It stores those samples only in its own small FIFO. No lane directs the others: all timing comes from comparing the shared counter with the start value plus the lane's own offset.

A reader walks the lane FIFOs in fixed rotation, starting at lane 0, and emits the bytes as a valid/ready stream in the order they were taken. When the requested number of bytes has left the block, it raises a one-cycle completion pulse. With the default parameters (4 lanes, step of 2 cycles), one byte is captured every 2 cycles and each lane samples once every 8 cycles.

Top module: `tilc_capture`

## Requirements
- R1: While reset is low and on the first cycle after it, `out_valid`, `done` and `overflow` are all 0 and `time_now` is 0.
- R2: `time_now` increases by exactly 1 on every clock edge and wraps from 2^CNT_W-1 to 0.
- R3: Let `T` be the latched start time. Output byte number k (counting from 0) equals the value `bus_in` held at the clock edge where `time_now` was `T + k*STEP`, taken modulo 2^CNT_W.
- R4: A capture yields exactly `sample_count` bytes. Lane i takes the bytes whose index k satisfies k mod LANES = i.
- R5: Bytes leave in increasing k. The reader serves lane 0, 1, …, LANES-1 and then lane 0 again. It withholds `out_valid` while the lane whose turn it is has no data, even if other lanes hold data.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` stays unchanged on the next cycle.
- R7: `done` is 1 for exactly one cycle, right after the clock edge that accepts the last byte. With a `sample_count` of 0, it is 1 in the cycle that follows the edge after the arming edge.
- R8: An `arm` pulse seen while a capture is still in progress has no effect on the running capture's bytes or byte count.
- R9: A start time whose sample window crosses the counter's rollover captures correctly, because the lane match uses modular arithmetic.
- R10: If lane i must store a byte while its 16-entry FIFO is full, that byte is dropped and `overflow[i]` becomes 1 and stays 1 until reset. Bytes stored earlier in the FIFO still come out unchanged. The capture never completes, so `done` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_in | input | DATA_W | Parallel bus being captured |
| arm | input | 1 | Starts a capture when no capture is running |
| start_time | input | CNT_W | Counter value at which lane 0 takes byte 0 |
| sample_count | input | LEN_W | Number of bytes to capture |
| out_ready | input | 1 | Consumer accepts `out_data` |
| out_data | output | DATA_W | Rebuilt byte stream |
| out_valid | output | 1 | `out_data` holds a byte |
| done | output | 1 | One-cycle pulse after the last byte is accepted |
| overflow | output | LANES | Sticky per-lane FIFO overflow flags |
| time_now | output | CNT_W | Shared free-running counter |

## Verification
The hardest states to reach from the ports are a lane overflow that hits only some lanes, and a capture window that crosses the counter rollover. For the first, the bench holds `out_ready` low through a 66-byte capture. Lanes 0 and 1 then need 17 slots and lanes 2 and 3 need 16, so only the first two lanes overflow. The bench then drains the block and checks that the stream stops after byte 63, the gap left by the lost byte 64. For the second, the bench waits on `time_now` until just before 2^16 and arms a start time there. The bus is driven as a fixed function of `time_now`, so every expected byte follows from arithmetic alone.

// File: rtl/tilc_pkg.sv
// Shared helpers for the interleaved capture block.
// Assumes the lane count is a power of two.
package tilc_pkg;

    // Number of bytes, out of 'total', that fall to lane 'idx' in a rotation of 'lanes'.
    function automatic int unsigned lane_share(int unsigned total, int unsigned idx,
                                               int unsigned lanes);
        if (total > idx)
            return (total - idx - 1) / lanes + 1;
        return 0;
    endfunction

endpackage

// File: rtl/tilc_fifo.sv
// Show-ahead FIFO private to one capture lane.
// Assumes the caller never pushes when full and never pops when empty.
module tilc_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [AW:0]   cnt;

    assign empty = (cnt == '0);
    assign full  = (cnt == (AW+1)'(DEPTH));
    assign rdata = mem[rp];

    // Storage write port.
    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= wp + AW'(1);
            if (pop)  rp <= rp + AW'(1);
            case ({push, pop})
                2'b10:   cnt <= cnt + (AW+1)'(1);
                2'b01:   cnt <= cnt - (AW+1)'(1);
                default: cnt <= cnt;
            endcase
        end
    end

    // R5
    pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
endmodule

// File: rtl/tilc_lane.sv
// One capture lane. It takes every LANES-th byte of a capture, starting at
// start_time + IDX*STEP on the shared counter, and keeps them in a private FIFO.
// Assumes start is issued only when no capture is running.
module tilc_lane
    import tilc_pkg::*;
#(
    parameter int W     = 8,
    parameter int CNT_W = 16,
    parameter int LEN_W = 8,
    parameter int LANES = 4,
    parameter int STEP  = 2,
    parameter int DEPTH = 16,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] start_time,
    input  logic [LEN_W-1:0] total,
    input  logic [CNT_W-1:0] tick,
    input  logic [W-1:0]     bus,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] OFFSET = CNT_W'(IDX * STEP);
    localparam logic [CNT_W-1:0] PERIOD = CNT_W'(LANES * STEP);

    logic [CNT_W-1:0] target;
    logic [LEN_W-1:0] left;
    logic             hit, full;

    // Modular distance to the next sampling instant; zero means sample now.
    assign hit = (left != '0) && ((tick - target) == '0);

    // Schedule of sampling instants and remaining share of the capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target <= '0;
            left   <= '0;
        end else if (start) begin
            target <= start_time + OFFSET;
            left   <= LEN_W'(lane_share(32'(total), IDX, LANES));
        end else if (hit) begin
            target <= target + PERIOD;
            left   <= left - LEN_W'(1);
        end
    end

    // Sticky flag for a byte lost to a full FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf <= 1'b0;
        else if (hit && full) ovf <= 1'b1;
    end

    tilc_fifo #(.W(W), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (hit && !full),
        .wdata (bus),
        .pop   (pop),
        .rdata (head),
        .empty (empty),
        .full  (full)
    );

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) ovf |=> ovf);
endmodule

// File: rtl/tilc_reader.sv
// Rebuilds the byte stream by serving the lane FIFOs in fixed rotation from lane 0.
// It holds the capture length and the busy state, and issues the done pulse.
// Assumes start is issued only while not busy.
module tilc_reader #(
    parameter int W     = 8,
    parameter int LEN_W = 8,
    parameter int LANES = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [LEN_W-1:0]          total,
    input  logic [LANES-1:0][W-1:0]   heads,
    input  logic [LANES-1:0]          empties,
    output logic [LANES-1:0]          pops,
    output logic [W-1:0]              out_data,
    output logic                      out_valid,
    input  logic                      out_ready,
    output logic                      done,
    output logic                      busy
);
    localparam int LW = $clog2(LANES);

    logic [LW-1:0]    rd_lane;
    logic [LEN_W-1:0] emitted, total_q;
    logic             hs;

    assign out_valid = busy && !empties[rd_lane];
    assign out_data  = heads[rd_lane];
    assign hs        = out_valid && out_ready;

    // Pop strobe to the lane being served.
    always_comb begin
        pops = '0;
        if (hs) pops[rd_lane] = 1'b1;
    end

    // Rotation, byte count and completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            rd_lane <= '0;
            emitted <= '0;
            total_q <= '0;
        end else begin
            done <= 1'b0;
            if (start) begin
                busy    <= 1'b1;
                rd_lane <= '0;
                emitted <= '0;
                total_q <= total;
            end else if (busy) begin
                if (emitted == total_q) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else if (hs) begin
                    emitted <= emitted + LEN_W'(1);
                    rd_lane <= rd_lane + LW'(1);
                    if (emitted + LEN_W'(1) == total_q) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));
    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
    // R5
    rotate_on_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hs && !start |=> $stable(rd_lane));
endmodule

// File: rtl/tilc_capture.sv
// Top of the interleaved bus capture. It owns the shared free-running counter,
// builds one lane per index, and hands their FIFOs to the reader.
// Assumes LANES is a power of two and start_time lies ahead of time_now when armed.
module tilc_capture #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16,
    parameter int LEN_W  = 8,
    parameter int LANES  = 4,
    parameter int STEP   = 2,
    parameter int DEPTH  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              arm,
    input  logic [CNT_W-1:0]  start_time,
    input  logic [LEN_W-1:0]  sample_count,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              done,
    output logic [LANES-1:0]  overflow,
    output logic [CNT_W-1:0]  time_now
);
    logic                          busy, start;
    logic [LANES-1:0][DATA_W-1:0]  heads;
    logic [LANES-1:0]              empties, pops;

    // An arm pulse counts only when no capture is running.
    assign start = arm && !busy;

    // Shared time base for all lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) time_now <= '0;
        else        time_now <= time_now + CNT_W'(1);
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        tilc_lane #(
            .W(DATA_W), .CNT_W(CNT_W), .LEN_W(LEN_W), .LANES(LANES),
            .STEP(STEP), .DEPTH(DEPTH), .IDX(i)
        ) u_lane (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start),
            .start_time (start_time),
            .total      (sample_count),
            .tick       (time_now),
            .bus        (bus_in),
            .pop        (pops[i]),
            .head       (heads[i]),
            .empty      (empties[i]),
            .ovf        (overflow[i])
        );
    end

    tilc_reader #(.W(DATA_W), .LEN_W(LEN_W), .LANES(LANES)) u_reader (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .total     (sample_count),
        .heads     (heads),
        .empties   (empties),
        .pops      (pops),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .done      (done),
        .busy      (busy)
    );

    // R2
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> time_now == $past(time_now) + CNT_W'(1));
    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !out_valid);
endmodule

// File: tb/tilc_capture_bench.sv
module tilc_capture_bench;
    localparam int STEP  = 2;
    localparam int LANES = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_in;
    logic        arm = 1'b0;
    logic [15:0] start_time = '0;
    logic [7:0]  sample_count = '0;
    logic        out_ready = 1'b0;
    logic [7:0]  out_data;
    logic        out_valid, done;
    logic [3:0]  overflow;
    logic [15:0] time_now;

    int vectors = 0;
    int misses  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] pat(logic [15:0] t);
        return (t[7:0] * 8'd29) ^ t[15:8];
    endfunction

    assign bus_in = pat(time_now);

    tilc_capture u_tilc_capture (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .arm(arm),
        .start_time(start_time), .sample_count(sample_count),
        .out_ready(out_ready), .out_data(out_data), .out_valid(out_valid),
        .done(done), .overflow(overflow), .time_now(time_now)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        arm = 1'b0;
        out_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Arms a capture and checks the whole stream plus the done pulse.
    // mode 0: ready always high, mode 1: ready low one cycle in four.
    task automatic capture(int offset, int count, int mode, bit inject);
        logic [15:0] st;
        int idx = 0;
        int cyc = 0;
        bit injected = 1'b0;
        st = time_now + 16'(offset);
        start_time = st;
        sample_count = 8'(count);
        arm = 1'b1;
        while (idx < count && cyc < count * STEP * 4 + offset + 60) begin
            @(negedge clk);
            cyc++;
            arm = 1'b0;
            if (inject && !injected && idx == count / 2) begin
                // R8: re-arm attempt while busy, different start and length
                start_time = time_now + 16'd3;
                sample_count = 8'd2;
                arm = 1'b1;
                injected = 1'b1;
            end
            if (done) check("R7 early done", 1, 0);
            out_ready = (mode == 0) ? 1'b1 : ((cyc % 4) != 0);
            if (out_valid && out_ready) begin
                // R3 R4 R5 byte k from instant start + k*STEP
                check("R3", out_data, pat(st + 16'(idx * STEP)));
                idx++;
            end
        end
        check("R4 count", idx, count);
        @(negedge clk);
        arm = 1'b0;
        if (count == 0) @(negedge clk);
        check("R7 done", done, 1);
        @(negedge clk);
        check("R7 done width", done, 0);
        check("R4 no extra", out_valid, 0);
        out_ready = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            misses++;
            vectors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    end

    initial begin
        logic [15:0] t0;
        do_reset();
        // R1 reset state
        check("R1 valid", out_valid, 0);
        check("R1 done", done, 0);
        check("R1 overflow", overflow, 0);
        check("R1 time", time_now, 0);
        // R2 counter step
        t0 = time_now;
        @(negedge clk);
        check("R2", time_now, t0 + 16'd1);

        // R4 R5 sweep of lengths and start offsets
        for (int c = 0; c <= 12; c++) capture(3 + (c % 4), c, 0, 1'b0);
        // R6 backpressure pattern
        capture(5, 40, 1, 1'b0);
        // R8 arm while busy ignored
        capture(4, 37, 1, 1'b1);

        // R9 window across rollover
        while (time_now != 16'hFFF0) @(negedge clk);
        capture(6, 20, 0, 1'b0);
        while (time_now != 16'hFFFF) @(negedge clk);
        @(negedge clk);
        check("R2 wrap", time_now, 0);

        // R10 partial overflow: 66 bytes, lanes 0 and 1 need 17 slots
        begin
            logic [15:0] st;
            int idx = 0;
            do_reset();
            st = time_now + 16'd4;
            start_time = st;
            sample_count = 8'd66;
            arm = 1'b1;
            @(negedge clk);
            arm = 1'b0;
            repeat (66 * STEP + 20) @(negedge clk);
            check("R10 flags", overflow, 4'b0011);
            check("R6 held valid", out_valid, 1);
            check("R6 held data", out_data, pat(st));
            for (int n = 0; n < 120; n++) begin
                out_ready = 1'b1;
                if (done) check("R10 no done", done, 0);
                if (out_valid) begin
                    check("R10 stored", out_data, pat(st + 16'(idx * STEP)));
                    idx++;
                end
                @(negedge clk);
            end
            check("R10 drained", idx, 64);
            check("R5 stall on gap", out_valid, 0);
            check("R10 sticky", overflow, 4'b0011);
            do_reset();
            check("R1 overflow cleared", overflow, 0);
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end
endmodule